// File: doc/BRIEF.md
# Single-Bus Add Sequencer

This block pairs a hardwired control step counter with a small datapath built around one shared internal bus. It runs one instruction: add the word held at a direct memory address into accumulator R0. Each instruction word carries an opcode in its top bits and the operand address in the rest. The step counter decodes into per-register load enables, bus drive enables, an ALU operand select and a carry-in. These move values among the program counter, memory address register, memory data register, instruction register, the Y and Z holding registers and R0.

Memory latency is variable. Each read strobe is answered by a one-cycle completion pulse that arrives one or more cycles later, and the returned word is captured into the data register on that pulse. The program counter is incremented through the ALU and written back while the instruction fetch is still in flight. The sequencer stalls only at the two steps that move memory data onto the bus. During a stall every register enable except the data-register capture is held off. Any opcode other than add finishes straight after the fetch.

Top module: `sbus_ctl_core`

## Requirements
- R1: Reset clears the program counter, R0, the step counter, `mem_rd` and `instr_done`. The first cycle after reset is released is the first fetch step, and the fetch strobe appears in the cycle after that.
- R2: Every read is a one-cycle `mem_rd` pulse. For a fetch, `mem_addr` equals the program counter value at the start of that instruction.
- R3: The program counter only ever advances by exactly one per instruction. The new value is visible in the cycle after the fetch strobe, whatever the memory latency.
- R4: Instruction word layout: bits [DATA_W-1 : DATA_W-OPC_W] hold the opcode and the low DATA_W-OPC_W bits hold the address. Opcode value 1 (`ADD_OPC`) selects the add.
- R5: For an add, a second one-cycle read is issued with `mem_addr` equal to the address field. R0 then becomes R0 plus the returned word, modulo 2^DATA_W, and R0 changes only in the cycle after `instr_done`.
- R6: For any other opcode, no operand read is made and R0 is unchanged. `instr_done` is asserted in the step after the instruction is loaded.
- R7: Let L1 be the fetch latency and L2 the operand latency, each counted from the strobe cycle to the completion cycle. An add then lasts 7+L1+L2 cycles and any other opcode 4+L1 cycles. `instr_done` is high only in the last of these cycles, and the next instruction's fetch step follows it directly.
- R8: At most one source drives the internal bus in any cycle, as seen on `bus_drv`. The bits are: bit 0 program counter, 1 Z, 2 data register, 3 address field, 4 R0.
- R9: The returned word is taken from `mem_rdata` only in the cycle `mem_done` is high. Other values present on `mem_rdata` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | DATA_W-OPC_W | Read address (memory address register) |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_rdata | input | DATA_W | Read data, valid while `mem_done` is high |
| mem_done | input | 1 | One-cycle memory-function-complete pulse |
| instr_done | output | 1 | High in the final step of each instruction |
| pc_out | output | DATA_W-OPC_W | Program counter |
| r0_out | output | DATA_W | Accumulator R0 |
| bus_drv | output | 5 | Internal bus drive enables, one bit per source |

## Verification
The assertions assume that memory answers every strobe with exactly one `mem_done` pulse, at least one cycle after the strobe, and never raises `mem_done` with no read outstanding. They also assume reset is held from time zero. The bench's memory responder keeps to this: it answers each strobe once, with latencies that cycle through 1 to 5. Outside the completion cycle it places a junk word on `mem_rdata`. The program mixes adds, two non-add opcodes, an arithmetic wrap, the top address, and an instruction that reads its own word.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int NUM_SRC = 5;
    localparam int SRC_PC  = 0;
    localparam int SRC_Z   = 1;
    localparam int SRC_MDR = 2;
    localparam int SRC_IRA = 3;
    localparam int SRC_R0  = 4;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR = 3'd0,
        ST_PC_UPD     = 3'd1,
        ST_IR_LOAD    = 3'd2,
        ST_OP_ADDR    = 3'd3,
        ST_OP_Y       = 3'd4,
        ST_SUM        = 3'd5,
        ST_WB         = 3'd6
    } step_e;

    // Datapath-facing controls
    typedef struct packed {
        logic [NUM_SRC-1:0] drv;
        logic pc_in;
        logic mar_in;
        logic ir_in;
        logic y_in;
        logic z_in;
        logic r0_in;
        logic rd;
        logic a_is_y;
        logic cin;
    } dp_ctl_t;

    typedef struct packed {
        dp_ctl_t dp;
        logic    wmfc;
        logic    fin;
    } ctl_t;

    // While stalled only the wait request survives; data capture lives in the datapath
    function automatic ctl_t gate_ctl(ctl_t c, logic stall);
        ctl_t r;
        r = c;
        if (stall) begin
            r.dp  = '0;
            r.fin = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/sbus_step_ctr.sv
module sbus_step_ctr
    import sbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wmfc,
    input  logic  fin,
    input  logic  rd_issue,
    input  logic  mem_done,
    output step_e step,
    output logic  stall
);

    logic  data_ready;
    step_e step_q;

    assign step  = step_q;
    assign stall = wmfc & ~data_ready;

    // Completion flag: set by the memory pulse, cleared when a new read is issued
    always_ff @(posedge clk) begin
        if (rst)
            data_ready <= 1'b0;
        else if (rd_issue)
            data_ready <= 1'b0;
        else if (mem_done)
            data_ready <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= ST_FETCH_ADDR;
        else if (!stall) begin
            if (fin)
                step_q <= ST_FETCH_ADDR;
            else
                step_q <= step_e'(step_q + 3'd1);
        end
    end

endmodule

// File: rtl/sbus_decode.sv
module sbus_decode
    import sbus_pkg::*;
#(
    parameter int               OPC_W   = 4,
    parameter logic [OPC_W-1:0] ADD_OPC = 1
) (
    input  step_e            step,
    input  logic [OPC_W-1:0] opcode,
    output ctl_t             ctl
);

    always_comb begin
        ctl = '0;
        unique case (step)
            ST_FETCH_ADDR: begin
                ctl.dp.drv[SRC_PC] = 1'b1;
                ctl.dp.mar_in      = 1'b1;
                ctl.dp.rd          = 1'b1;
                ctl.dp.cin         = 1'b1;
                ctl.dp.z_in        = 1'b1;
            end
            ST_PC_UPD: begin
                ctl.dp.drv[SRC_Z]  = 1'b1;
                ctl.dp.pc_in       = 1'b1;
            end
            ST_IR_LOAD: begin
                ctl.dp.drv[SRC_MDR] = 1'b1;
                ctl.dp.ir_in        = 1'b1;
                ctl.wmfc            = 1'b1;
            end
            ST_OP_ADDR: begin
                if (opcode == ADD_OPC) begin
                    ctl.dp.drv[SRC_IRA] = 1'b1;
                    ctl.dp.mar_in       = 1'b1;
                    ctl.dp.rd           = 1'b1;
                end else begin
                    ctl.fin = 1'b1;
                end
            end
            ST_OP_Y: begin
                ctl.dp.drv[SRC_R0] = 1'b1;
                ctl.dp.y_in        = 1'b1;
            end
            ST_SUM: begin
                ctl.dp.drv[SRC_MDR] = 1'b1;
                ctl.dp.a_is_y       = 1'b1;
                ctl.dp.z_in         = 1'b1;
                ctl.wmfc            = 1'b1;
            end
            ST_WB: begin
                ctl.dp.drv[SRC_Z]  = 1'b1;
                ctl.dp.r0_in       = 1'b1;
                ctl.fin            = 1'b1;
            end
            default: ctl.fin = 1'b1;
        endcase
    end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  dp_ctl_t            ctl,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_done,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  pc,
    output logic [DATA_W-1:0]  r0,
    output logic [OPC_W-1:0]   opcode
);

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] mdr_q, ir_q, y_q, z_q, r0_q;
    logic [DATA_W-1:0] src [NUM_SRC];
    logic [DATA_W-1:0] bus, alu_a, alu_sum;
    logic              rd_q;

    assign src[SRC_PC]  = DATA_W'(pc_q);
    assign src[SRC_Z]   = z_q;
    assign src[SRC_MDR] = mdr_q;
    assign src[SRC_IRA] = DATA_W'(ir_q[ADDR_W-1:0]);
    assign src[SRC_R0]  = r0_q;

    // Shared bus: OR of enabled sources (at most one enabled)
    always_comb begin
        bus = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ctl.drv[i])
                bus = bus | src[i];
        end
    end

    assign alu_a   = ctl.a_is_y ? y_q : '0;
    assign alu_sum = alu_a + bus + DATA_W'(ctl.cin);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            y_q   <= '0;
            z_q   <= '0;
            r0_q  <= '0;
            rd_q  <= 1'b0;
        end else begin
            rd_q <= ctl.rd;
            if (ctl.pc_in)  pc_q  <= bus[ADDR_W-1:0];
            if (ctl.mar_in) mar_q <= bus[ADDR_W-1:0];
            if (ctl.ir_in)  ir_q  <= bus;
            if (ctl.y_in)   y_q   <= bus;
            if (ctl.z_in)   z_q   <= alu_sum;
            if (ctl.r0_in)  r0_q  <= bus;
            if (mem_done)   mdr_q <= mem_rdata;
        end
    end

    assign mem_addr = mar_q;
    assign mem_rd   = rd_q;
    assign pc       = pc_q;
    assign r0       = r0_q;
    assign opcode   = ir_q[DATA_W-1 -: OPC_W];

endmodule

// File: rtl/sbus_ctl_core.sv
module sbus_ctl_core
    import sbus_pkg::*;
#(
    parameter int               DATA_W  = 16,
    parameter int               OPC_W   = 4,
    parameter logic [OPC_W-1:0] ADD_OPC = 1,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_done,
    output logic               instr_done,
    output logic [ADDR_W-1:0]  pc_out,
    output logic [DATA_W-1:0]  r0_out,
    output logic [NUM_SRC-1:0] bus_drv
);

    step_e            step;
    logic             stall;
    logic [OPC_W-1:0] opcode;
    ctl_t             ctl_raw, ctl_g;

    sbus_decode #(.OPC_W(OPC_W), .ADD_OPC(ADD_OPC)) dec_i (
        .step   (step),
        .opcode (opcode),
        .ctl    (ctl_raw)
    );

    assign ctl_g = gate_ctl(ctl_raw, stall);

    sbus_step_ctr ctr_i (
        .clk      (clk),
        .rst      (rst),
        .wmfc     (ctl_raw.wmfc),
        .fin      (ctl_raw.fin),
        .rd_issue (ctl_g.dp.rd),
        .mem_done (mem_done),
        .step     (step),
        .stall    (stall)
    );

    sbus_datapath #(.DATA_W(DATA_W), .OPC_W(OPC_W)) dp_i (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl_g.dp),
        .mem_rdata (mem_rdata),
        .mem_done  (mem_done),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .pc        (pc_out),
        .r0        (r0_out),
        .opcode    (opcode)
    );

    assign instr_done = ctl_g.fin;
    assign bus_drv    = ctl_g.dp.drv;

endmodule

// File: rtl/sbus_ctl_chk.sv
module sbus_ctl_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int NSRC   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              instr_done,
    input logic [ADDR_W-1:0] pc_out,
    input logic [DATA_W-1:0] r0_out,
    input logic [NSRC-1:0]   bus_drv
);

    // R8
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_drv));

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> !instr_done);

    // R7
    done_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> ##1 mem_rd);

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_out != $past(pc_out)) |-> (pc_out == ADDR_W'($past(pc_out) + 1'b1)));

    // R5
    r0_update_chk: assert property (@(posedge clk) disable iff (rst)
        (r0_out != $past(r0_out)) |-> $past(instr_done));

endmodule

bind sbus_ctl_core sbus_ctl_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NSRC   (sbus_pkg::NUM_SRC)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mem_rd     (mem_rd),
    .instr_done (instr_done),
    .pc_out     (pc_out),
    .r0_out     (r0_out),
    .bus_drv    (bus_drv)
);

// File: tb/sbus_ctl_core_tb.sv
`timescale 1ns/1ps
module sbus_ctl_core_tb_top;

    localparam int DATA_W = 16;
    localparam int OPC_W  = 4;
    localparam int ADDR_W = DATA_W - OPC_W;
    localparam int N_INSTR = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [DATA_W-1:0] mem_rdata = 16'hDEAD;
    logic              mem_done = 1'b0;
    logic              instr_done;
    logic [ADDR_W-1:0] pc_out;
    logic [DATA_W-1:0] r0_out;
    logic [4:0]        bus_drv;

    always #2.5 clk = ~clk;

    sbus_ctl_core #(.DATA_W(DATA_W), .OPC_W(OPC_W), .ADD_OPC(4'h1)) dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_done(mem_done), .instr_done(instr_done),
        .pc_out(pc_out), .r0_out(r0_out), .bus_drv(bus_drv)
    );

    logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];

    typedef struct {
        int                pc_next;
        logic [DATA_W-1:0] r0;
        int                gap;
    } done_t;

    int     exp_rd_addr[$];
    bit     exp_rd_fetch[$];
    done_t  exp_done_q[$];

    int n_checks = 0;
    int n_fail   = 0;
    int n_done   = 0;
    int bus_bad  = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lat_of(int k);
        return 1 + (k * 3) % 5;
    endfunction

    // Driver: loads the program and pushes the expected items
    task automatic drive_program();
        logic [DATA_W-1:0] r0m;
        int k;
        for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = '0;
        mem[0] = 16'h1100; mem[12'h100] = 16'h0005;
        mem[1] = 16'h1101; mem[12'h101] = 16'h0007;
        mem[2] = 16'h3102;                          // non-add (R6)
        mem[3] = 16'h1103; mem[12'h103] = 16'hFFF8; // wraps (R5)
        mem[4] = 16'h0000;                          // opcode 0 (R6)
        mem[5] = 16'h1FFF; mem[12'hFFF] = 16'h1234; // top address (R4)
        mem[6] = 16'h1006;                          // reads its own word
        r0m = '0;
        k = 0;
        for (int pc = 0; pc < N_INSTR; pc++) begin
            done_t d;
            int l1, l2;
            logic [DATA_W-1:0] w;
            w = mem[pc];
            exp_rd_addr.push_back(pc); exp_rd_fetch.push_back(1'b1);
            l1 = lat_of(k); k++;
            if (w[DATA_W-1 -: OPC_W] == 4'h1) begin
                exp_rd_addr.push_back(int'(w[ADDR_W-1:0])); exp_rd_fetch.push_back(1'b0);
                l2 = lat_of(k); k++;
                r0m = r0m + mem[w[ADDR_W-1:0]];
                d.gap = 7 + l1 + l2;
            end else begin
                d.gap = 4 + l1;
            end
            d.pc_next = pc + 1;
            d.r0 = r0m;
            exp_done_q.push_back(d);
        end
    endtask

    // Memory responder and monitor, all at the falling edge
    int                cyc = -1;
    int                last_done = -1;
    int                rsp_k = 0;
    bit                pend = 0;
    int                cnt = 0;
    logic [ADDR_W-1:0] pend_addr;
    bit                pc_chk = 0;
    int                pc_exp = 0;
    bit                r0_chk = 0;
    logic [DATA_W-1:0] r0_exp = '0;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if ($countones(bus_drv) > 1) bus_bad++;
            if (cyc == 0) check(mem_rd == 1'b0, "R1", "strobe in first fetch step", mem_rd, 0);
            if (cyc == 1) check(mem_rd == 1'b1, "R1", "strobe in second cycle", mem_rd, 1);
            if (pc_chk) begin
                check(pc_out == pc_exp, "R3", "pc after fetch strobe", pc_out, pc_exp);
                pc_chk = 0;
            end
            if (r0_chk) begin
                check(r0_out == r0_exp, "R5", "r0 after instruction", r0_out, r0_exp);
                r0_chk = 0;
            end
            mem_done  = 1'b0;
            mem_rdata = 16'hDEAD ^ DATA_W'(cyc);   // junk (R9)
            if (pend) begin
                cnt--;
                if (cnt == 0) begin
                    mem_done  = 1'b1;
                    mem_rdata = mem[pend_addr];
                    pend      = 0;
                end
            end
            if (mem_rd) begin
                pend = 1; cnt = lat_of(rsp_k); rsp_k++;
                pend_addr = mem_addr;
                if (exp_rd_addr.size() > 0) begin
                    int  ea;
                    bit  fe;
                    ea = exp_rd_addr.pop_front();
                    fe = exp_rd_fetch.pop_front();
                    check(int'(mem_addr) == ea, fe ? "R2" : "R5", "read address", mem_addr, ea);
                    if (fe) begin pc_chk = 1; pc_exp = ea + 1; end
                end
            end
            if (instr_done && exp_done_q.size() > 0) begin
                done_t d;
                d = exp_done_q.pop_front();
                check(int'(pc_out) == d.pc_next, "R3", "pc at instruction end", pc_out, d.pc_next);
                check(cyc - last_done == d.gap, "R7", "instruction length", cyc - last_done, d.gap);
                last_done = cyc;
                r0_chk = 1; r0_exp = d.r0;
                n_done++;
            end
        end
    end

    initial begin
        drive_program();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_out == '0,      "R1", "pc in reset", pc_out, 0);
        check(r0_out == '0,      "R1", "r0 in reset", r0_out, 0);
        check(mem_rd == 1'b0,    "R1", "strobe in reset", mem_rd, 0);
        check(instr_done == 1'b0,"R1", "done in reset", instr_done, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        for (int c = 0; c < 5000 && n_done < N_INSTR; c++) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        check(n_done == N_INSTR, "R7", "watchdog: instructions completed", n_done, N_INSTR);
        check(exp_rd_addr.size() == 0, "R6", "expected reads left over", exp_rd_addr.size(), 0);
        check(bus_bad == 0, "R8", "cycles with several bus drivers", bus_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule